// File: doc/BRIEF.md
# Four-State Mealy Sequencer with Selectable State Encoding

This block is a synchronous four-state Mealy machine. It takes a single-bit input `x` and drives a single-bit output `z`. The transition and output table is fixed. In every state, `x=0` advances the machine by one state and `x=1` advances it by two, with wrap-around from the last state to the first. The output `z` depends on both the present state and `x`.

Two compile-time parameters pick how the state register is realised:
- `ENCODING` selects the state encoding: 0 for binary, 1 for Gray code, 2 for one-hot.
- `FF_KIND` selects the storage cell: 0 for JK-type, 1 for SR-type.

Each state bit is held in an explicit cell of the chosen type. The cell inputs come from excitation equations, and every don't-care term is resolved to a fixed value.

All six variants behave the same at the ports. The raw state bits are shown on a 4-bit debug bus, so any variant can be dropped in where encoding cost or cell type matters.

Top module: `mealy_fsm4`

## Requirements
- R1: A synchronous active-high reset puts the machine in S0 at the next rising clock edge, whatever `x` is during that cycle.
- R2: On each rising edge without reset, S0 goes to S1 when `x=0` and to S2 when `x=1`. S1 goes to S2 or S3, S2 goes to S3 or S0, and S3 goes to S0 or S1, for `x=0` and `x=1` respectively.
- R3: `z` is combinational from the present state and `x`:
  - With `x=0`, `z` is 1 only in S2.
  - With `x=1`, `z` is 1 only in S0 and S3.
- R4: With `ENCODING=0` (binary), `state_bits[1:0]` reads S0=00, S1=01, S2=10, S3=11.
- R5: With `ENCODING=1` (Gray), `state_bits[1:0]` reads S0=00, S1=01, S2=11, S3=10.
- R6: With `ENCODING=2` (one-hot), `state_bits[3:0]` reads S0=0001, S1=0010, S2=0100, S3=1000, and exactly one bit is set after reset.
- R7: The JK variant (`FF_KIND=0`) and the SR variant (`FF_KIND=1`) of the same encoding show identical `z` and `state_bits` on every cycle. SR cells never see set and reset asserted together.
- R8: For the two-bit encodings, `state_bits[3:2]` is always 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to S0 |
| x | input | 1 | Machine input |
| z | output | 1 | Mealy output, from present state and `x` |
| state_bits | output | 4 | Raw state register bits, zero-padded above the encoding width |

## Verification
All six encoding and cell combinations run side by side on the same input stream.

The first pattern set is an exhaustive sweep of every 8-bit `x` sequence, each started from reset. It reaches every state with both input values, so every table entry is exercised and a single wrong arc or output bit is exposed.

A long pseudo-random stream then follows, with periodic resets asserted while `x` toggles. This shows that reset overrides the input, and it exercises long runs where the JK and SR excitation paths could drift apart.

Comparing the JK and SR instances of each encoding separates a cell-equation fault from a table fault.

// File: rtl/fsm4_pkg.sv
package fsm4_pkg;
  localparam int ENC_BINARY = 0;
  localparam int ENC_GRAY   = 1;
  localparam int ENC_ONEHOT = 2;
  localparam int FF_JK      = 0;
  localparam int FF_SR      = 1;
  localparam int NUM_STATES = 4;
  localparam int DBG_W      = 4;
  localparam int IDX_W      = $clog2(NUM_STATES);

  typedef logic [IDX_W-1:0] sidx_t;
  typedef logic [DBG_W-1:0] code_t;

  function automatic int state_width(int enc);
    return (enc == ENC_ONEHOT) ? NUM_STATES : IDX_W;
  endfunction

  function automatic code_t encode(int enc, sidx_t s);
    code_t c;
    c = '0;
    case (enc)
      ENC_GRAY:   c[IDX_W-1:0] = s ^ (s >> 1);
      ENC_ONEHOT: c[s] = 1'b1;
      default:    c[IDX_W-1:0] = s;
    endcase
    return c;
  endfunction

  function automatic logic code_valid(int enc, code_t c);
    if (enc == ENC_ONEHOT) return ($countones(c) == 1);
    return (c[DBG_W-1:IDX_W] == '0);
  endfunction

  function automatic sidx_t decode(int enc, code_t c);
    sidx_t s;
    s = '0;
    case (enc)
      ENC_GRAY: begin
        s[1] = c[1];
        s[0] = c[1] ^ c[0];
      end
      ENC_ONEHOT: begin
        for (int i = 0; i < NUM_STATES; i++)
          if (c[i]) s = sidx_t'(i);
      end
      default: s = c[IDX_W-1:0];
    endcase
    return s;
  endfunction

  function automatic sidx_t next_state(sidx_t s, logic x);
    return x ? sidx_t'(s + 2'd2) : sidx_t'(s + 2'd1);
  endfunction

  function automatic logic out_of(sidx_t s, logic x);
    if (x) return (s == 2'd0) || (s == 2'd3);
    return (s == 2'd2);
  endfunction
endpackage

// File: rtl/fsm4_jk_cell.sv
module fsm4_jk_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else begin
      case ({j, k})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end

  // R2
  jk_set_chk: assert property (@(posedge clk) disable iff (rst)
    (j && !k) |=> q);
  // R2
  jk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (k && !j) |=> !q);
endmodule

// File: rtl/fsm4_sr_cell.sv
module fsm4_sr_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic s,
  input  logic r,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)    q <= RST_VAL;
    else if (s) q <= 1'b1;
    else if (r) q <= 1'b0;
  end

  // R7
  sr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(s && r));
  // R2
  sr_set_chk: assert property (@(posedge clk) disable iff (rst)
    s |=> q);
endmodule

// File: rtl/fsm4_state_bit.sv
module fsm4_state_bit #(
  parameter int   FF_KIND = 0,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  import fsm4_pkg::*;

  generate
    if (FF_KIND == FF_SR) begin : g_sr
      logic s_in, r_in;
      assign s_in = d & ~q;
      assign r_in = ~d & q;
      fsm4_sr_cell #(.RST_VAL(RST_VAL)) i_cell (
        .clk(clk), .rst(rst), .s(s_in), .r(r_in), .q(q));
    end else begin : g_jk
      logic j_in, k_in;
      assign j_in = d;
      assign k_in = ~d;
      fsm4_jk_cell #(.RST_VAL(RST_VAL)) i_cell (
        .clk(clk), .rst(rst), .j(j_in), .k(k_in), .q(q));
    end
  endgenerate
endmodule

// File: rtl/fsm4_next_logic.sv
module fsm4_next_logic #(
  parameter int ENCODING = 0,
  parameter int SW       = 2
) (
  input  logic [SW-1:0] q,
  input  logic          x,
  output logic [SW-1:0] d,
  output logic          z
);
  import fsm4_pkg::*;

  code_t q_pad, d_code;
  sidx_t cur_idx;
  logic  legal;

  always_comb begin
    q_pad         = '0;
    q_pad[SW-1:0] = q;
    legal         = code_valid(ENCODING, q_pad);
    cur_idx       = legal ? decode(ENCODING, q_pad) : '0;
    d_code        = legal ? encode(ENCODING, next_state(cur_idx, x))
                          : encode(ENCODING, '0);
    d             = d_code[SW-1:0];
    z             = legal & out_of(cur_idx, x);
  end
endmodule

// File: rtl/mealy_fsm4.sv
module mealy_fsm4 #(
  parameter int ENCODING = 0,
  parameter int FF_KIND  = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       x,
  output logic       z,
  output logic [3:0] state_bits
);
  import fsm4_pkg::*;

  localparam int    SW       = state_width(ENCODING);
  localparam code_t RST_CODE = encode(ENCODING, '0);

  logic [SW-1:0] q, d;

  fsm4_next_logic #(.ENCODING(ENCODING), .SW(SW)) i_next (
    .q(q), .x(x), .d(d), .z(z));

  generate
    for (genvar b = 0; b < SW; b++) begin : g_bit
      fsm4_state_bit #(.FF_KIND(FF_KIND), .RST_VAL(RST_CODE[b])) i_bit (
        .clk(clk), .rst(rst), .d(d[b]), .q(q[b]));
    end
    if (SW < DBG_W) begin : g_pad
      assign state_bits = {{(DBG_W-SW){1'b0}}, q};
    end else begin : g_full
      assign state_bits = q;
    end
  endgenerate

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_bits == RST_CODE));
  // R2
  next_state_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (decode(ENCODING, state_bits) ==
              next_state(decode(ENCODING, $past(state_bits)), $past(x))));
  // R6
  onehot_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (ENCODING == ENC_ONEHOT) |-> ($countones(state_bits) == 1));
  // R8
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ENCODING != ENC_ONEHOT) |-> (state_bits[3:2] == 2'b00));
endmodule

// File: tb/test_mealy_fsm4.sv
`timescale 1ns/1ps
module test_mealy_fsm4;
  localparam int NCFG = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic       z_a  [NCFG];
  logic [3:0] st_a [NCFG];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [1:0] ref_s = 2'd0;
  bit ref_ok   = 0;
  bit prev_rst = 0;

  always #4 clk = ~clk;

  generate
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      mealy_fsm4 #(.ENCODING(g / 2), .FF_KIND(g % 2)) i_mealy_fsm4 (
        .clk(clk), .rst(rst), .x(x), .z(z_a[g]), .state_bits(st_a[g]));
    end
  endgenerate

  function automatic logic [3:0] exp_code(int e, logic [1:0] s);
    if (e == 1) return {2'b00, s ^ (s >> 1)};
    if (e == 2) return 4'b0001 << s;
    return {2'b00, s};
  endfunction

  function automatic string enc_tag(int e);
    if (e == 0) return "R4+R8";
    if (e == 1) return "R5+R8";
    return "R6";
  endfunction

  task automatic cmp(string tag, int g, logic [3:0] act, logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s cfg%0d act=%b exp=%b", tag, g, act, expv);
    end
  endtask

  task automatic cyc(input logic xv, input logic rv);
    @(negedge clk);
    x   = xv;
    rst = rv;
    #1;
    if (ref_ok) begin
      for (int g = 0; g < NCFG; g++) begin
        cmp($sformatf("%s %s state", prev_rst ? "R1" : "R2", enc_tag(g / 2)),
            g, st_a[g], exp_code(g / 2, ref_s));
        cmp("R3 z", g, {3'b000, z_a[g]},
            {3'b000, xv ? (ref_s == 2'd0 || ref_s == 2'd3) : (ref_s == 2'd2)});
        if (g % 2 == 1) begin
          cmp("R7 state jk-vs-sr", g, st_a[g], st_a[g-1]);
          cmp("R7 z jk-vs-sr", g, {3'b000, z_a[g]}, {3'b000, z_a[g-1]});
        end
      end
    end
    @(posedge clk);
    if (rv) begin
      ref_s  = 2'd0;
      ref_ok = 1;
    end else if (ref_ok) begin
      ref_s = xv ? ref_s + 2'd2 : ref_s + 2'd1;
    end
    prev_rst = rv;
  endtask

  initial begin
    logic [15:0] lfsr;
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b1);
    // R2 R3: exhaustive 8-step input sequences, each from reset (R1 with x toggled)
    for (int p = 0; p < 256; p++) begin
      cyc(p[0] ^ p[3], 1'b1);
      for (int i = 0; i < 8; i++) cyc(p[i], 1'b0);
    end
    // R7: long pseudo-random run with periodic resets
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], (n % 97) == 96);
    end
    cyc(1'b0, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule